// File: doc/BRIEF.md
# Masked Register-Block Transfer Sequencer

This block moves a group of 64-bit floating-point registers to or from one packed region of memory. A start command carries a base byte address, a direction, a selection mask with one bit per register, and a vector length. The sequencer walks the registers from index 0 upward. Each register whose mask bit is set, and whose index is below the vector length, takes part in one doubleword transfer. Memory is dense: the k-th selected register pairs with the doubleword at base + 8k, wherever that register sits in the file.

A load reads each doubleword in turn and writes it into the matching register. Registers that are not selected are never written. A store reads each selected register through the register-file read port and writes it to memory. The memory port is a plain valid/ready request channel with a response strobe, and only one request is in flight at a time. A one-cycle done pulse ends every command, including a command that selects nothing.

Top module: `fpr_mask_xfer_seq`

## Requirements
- R1: While reset is high, and in the cycle after it falls, busy, done, mem_req_valid and rf_wr_en are all low.
- R2: For a load (start_store = 0), the k-th selected register, counting from 0 in ascending index order, receives the doubleword read from address base + 8k. rf_wr_en pulses in the same cycle as mem_rsp_valid.
- R3: For a load, a register whose mask bit is 0 (bit i of start_mask belongs to register i) is never written and keeps its value.
- R4: For a store (start_store = 1, mem_req_write = 1), the content of the k-th selected register is written to address base + 8k. No other memory word is written and no register is written.
- R5: The request address equals base plus 8 times the number of transfers already completed. While mem_req_valid is high and mem_req_ready is low, the request and its address stay unchanged.
- R6: After a request is accepted (valid and ready in the same cycle), no new request is raised before mem_rsp_valid has been seen.
- R7: Only registers with index below min(start_vl, NREG) take part. A start_vl value above NREG acts as NREG, and mask bits at or above the limit are ignored.
- R8: If no register is selected after the length limit is applied, done is high exactly one cycle after the start cycle and no memory request is made.
- R9: done is a single-cycle pulse in the cycle after the last response. busy is high from the cycle after an accepted start until the command ends.
- R10: A start raised while busy is high is ignored and does not change the command in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command strobe, taken only when idle |
| start_store | input | 1 | 1 = store registers to memory, 0 = load |
| start_base | input | AW | Byte address of the first doubleword |
| start_mask | input | NREG | Register selection, bit i for register i |
| start_vl | input | VLW | Vector length limit |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_write | output | 1 | Request is a write |
| mem_req_addr | output | AW | Request byte address |
| mem_req_wdata | output | 64 | Write data |
| mem_rsp_valid | input | 1 | Response for the outstanding request |
| mem_rsp_rdata | input | 64 | Read data for a load response |
| rf_rd_idx | output | IDXW | Register-file read index |
| rf_rd_data | input | 64 | Register-file read data, same cycle |
| rf_wr_en | output | 1 | Register-file write strobe |
| rf_wr_idx | output | IDXW | Register-file write index |
| rf_wr_data | output | 64 | Register-file write data |

## Verification
Some properties hold on every cycle and are checked by assertions. The request is held while it waits, nothing is issued while a response is pending, the address steps by exactly 8 per completed transfer, register indices rise within a command, no write reaches an unselected register, done lasts one cycle, and an empty selection finishes at once. Other behaviour can only be shown by the bench's scenarios. These cover the data landing in the right registers and memory words, the dense packing against a scattered mask, the length clamp, and a second start ignored mid-command. The bench sweeps every mask of an 8-register build in both directions, with several lengths and base offsets and a memory that stalls irregularly.

// File: rtl/mxs_pkg.sv
package mxs_pkg;

    localparam int unsigned MAX_REGS   = 64;
    localparam int unsigned XFER_BYTES = 8;
    localparam int unsigned WORD_W     = 64;

    typedef logic [WORD_W-1:0] dword_t;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ISSUE = 2'd1,
        SEQ_AWAIT = 2'd2
    } seq_state_e;

    typedef enum logic {
        DIR_LOAD  = 1'b0,
        DIR_STORE = 1'b1
    } xfer_dir_e;

    typedef struct packed {
        logic       hit;
        logic [5:0] pos;
    } pick_t;

    // Lowest set bit of a selection vector; hit is clear for an empty vector.
    function automatic pick_t lowest_set(input logic [MAX_REGS-1:0] bits);
        pick_t r;
        r.hit = 1'b0;
        r.pos = '0;
        for (int i = MAX_REGS - 1; i >= 0; i--) begin
            if (bits[i]) begin
                r.hit = 1'b1;
                r.pos = 6'(i);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/mxs_pick.sv
module mxs_pick
    import mxs_pkg::*;
#(
    parameter int unsigned NREG = 64,
    localparam int unsigned IDXW = $clog2(NREG)
) (
    input  logic [NREG-1:0] cand,
    output logic            found,
    output logic [IDXW-1:0] idx
);

    logic [MAX_REGS-1:0] wide;
    pick_t               sel;

    assign wide  = MAX_REGS'(cand);
    assign sel   = lowest_set(wide);
    assign found = sel.hit;
    assign idx   = sel.pos[IDXW-1:0];

    // R2: the chosen register is selected and nothing below it is.
    always_comb begin
        if (found) begin
            assert_pick_selected_R2: assert (cand[idx]);
            assert_pick_lowest_R2: assert ((cand & ((NREG'(1) << idx) - NREG'(1))) == '0);
        end else begin
            assert_pick_empty_R8: assert (cand == '0);
        end
    end

endmodule

// File: rtl/mxs_addr.sv
module mxs_addr
    import mxs_pkg::*;
#(
    parameter int unsigned AW = 48
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] base,
    output logic [AW-1:0] addr
);

    localparam logic [AW-1:0] STRIDE = AW'(XFER_BYTES);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
        end else if (load) begin
            addr <= base;
        end else if (step) begin
            addr <= addr + STRIDE;
        end
    end

    // R5: the address advances only after a completed transfer, one doubleword at a time.
    assert_addr_stride_R5: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> (addr == $past(addr) + STRIDE));
    assert_addr_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!step && !load) |=> $stable(addr));

endmodule

// File: rtl/mxs_fsm.sv
module mxs_fsm
    import mxs_pkg::*;
#(
    parameter int unsigned NREG = 64,
    localparam int unsigned IDXW = $clog2(NREG),
    localparam int unsigned VLW  = $clog2(NREG + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            start_store,
    input  logic [NREG-1:0] start_mask,
    input  logic [VLW-1:0]  start_vl,
    output logic [NREG-1:0] cand,
    input  logic            found,
    input  logic [IDXW-1:0] pick_idx,
    output logic            req_valid,
    input  logic            req_ready,
    input  logic            rsp_valid,
    output logic            store_mode,
    output logic [IDXW-1:0] cur_idx,
    output logic            addr_load,
    output logic            addr_step,
    output logic            wr_en,
    output logic            busy,
    output logic            done
);

    seq_state_e      state_q;
    xfer_dir_e       dir_q;
    logic [NREG-1:0] rem_q;
    logic [IDXW-1:0] idx_q;
    logic            done_q;

    logic [VLW-1:0]  vl_eff;
    logic [NREG-1:0] in_range;
    logic            accept;
    logic            finish;

    assign vl_eff = (start_vl > VLW'(NREG)) ? VLW'(NREG) : start_vl;

    for (genvar g = 0; g < NREG; g++) begin : g_range
        assign in_range[g] = (VLW'(g) < vl_eff);
    end

    assign accept = start && (state_q == SEQ_IDLE);
    assign finish = (state_q == SEQ_AWAIT) && rsp_valid;

    always_comb begin
        if (state_q == SEQ_IDLE) begin
            cand = start_mask & in_range;
        end else begin
            cand = rem_q & ~(NREG'(1) << idx_q);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            dir_q   <= DIR_LOAD;
            rem_q   <= '0;
            idx_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                SEQ_IDLE: begin
                    if (start) begin
                        dir_q <= xfer_dir_e'(start_store);
                        rem_q <= cand;
                        idx_q <= pick_idx;
                        if (found) begin
                            state_q <= SEQ_ISSUE;
                        end else begin
                            done_q <= 1'b1;
                        end
                    end
                end
                SEQ_ISSUE: begin
                    if (req_ready) begin
                        state_q <= SEQ_AWAIT;
                    end
                end
                SEQ_AWAIT: begin
                    if (rsp_valid) begin
                        rem_q <= cand;
                        idx_q <= pick_idx;
                        if (found) begin
                            state_q <= SEQ_ISSUE;
                        end else begin
                            state_q <= SEQ_IDLE;
                            done_q  <= 1'b1;
                        end
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign req_valid  = (state_q == SEQ_ISSUE);
    assign store_mode = (dir_q == DIR_STORE);
    assign cur_idx    = idx_q;
    assign addr_load  = accept;
    assign addr_step  = finish;
    assign wr_en      = finish && (dir_q == DIR_LOAD);
    assign busy       = (state_q != SEQ_IDLE);
    assign done       = done_q;

    // R1: quiet outputs right after reset.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!req_valid && !done && !busy && !wr_en));
    // R2: registers are visited in strictly ascending order within a command.
    assert_ascending_R2: assert property (@(posedge clk) disable iff (rst)
        (finish && found) |=> (cur_idx > $past(cur_idx)));
    // R3: a load never writes a register outside the remaining selection.
    assert_keep_unselected_R3: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> rem_q[idx_q]);
    // R5: a waiting request holds its register index.
    assert_req_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> (req_valid && $stable(cur_idx)));
    // R6: one request in flight.
    assert_one_outstanding_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_valid);
    assert_no_reissue_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && !req_valid && !rsp_valid) |=> !req_valid);
    // R8: an empty selection ends at once with no request.
    assert_empty_done_R8: assert property (@(posedge clk) disable iff (rst)
        (accept && !found) |=> (done && !req_valid && !busy));
    // R9: done lasts one cycle.
    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R10: a start while busy leaves the direction alone.
    assert_busy_ignores_start_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(store_mode));

endmodule

// File: rtl/fpr_mask_xfer_seq.sv
module fpr_mask_xfer_seq
    import mxs_pkg::*;
#(
    parameter int unsigned NREG = 64,
    parameter int unsigned AW   = 48,
    localparam int unsigned IDXW = $clog2(NREG),
    localparam int unsigned VLW  = $clog2(NREG + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            start_store,
    input  logic [AW-1:0]   start_base,
    input  logic [NREG-1:0] start_mask,
    input  logic [VLW-1:0]  start_vl,
    output logic            busy,
    output logic            done,
    output logic            mem_req_valid,
    input  logic            mem_req_ready,
    output logic            mem_req_write,
    output logic [AW-1:0]   mem_req_addr,
    output logic [63:0]     mem_req_wdata,
    input  logic            mem_rsp_valid,
    input  logic [63:0]     mem_rsp_rdata,
    output logic [IDXW-1:0] rf_rd_idx,
    input  logic [63:0]     rf_rd_data,
    output logic            rf_wr_en,
    output logic [IDXW-1:0] rf_wr_idx,
    output logic [63:0]     rf_wr_data
);

    logic [NREG-1:0] cand;
    logic            found;
    logic [IDXW-1:0] pick_idx;
    logic [IDXW-1:0] cur_idx;
    logic            addr_load;
    logic            addr_step;
    logic            store_mode;
    dword_t          load_word;

    mxs_fsm #(.NREG(NREG)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .start_store(start_store),
        .start_mask (start_mask),
        .start_vl   (start_vl),
        .cand       (cand),
        .found      (found),
        .pick_idx   (pick_idx),
        .req_valid  (mem_req_valid),
        .req_ready  (mem_req_ready),
        .rsp_valid  (mem_rsp_valid),
        .store_mode (store_mode),
        .cur_idx    (cur_idx),
        .addr_load  (addr_load),
        .addr_step  (addr_step),
        .wr_en      (rf_wr_en),
        .busy       (busy),
        .done       (done)
    );

    mxs_pick #(.NREG(NREG)) u_pick (
        .cand (cand),
        .found(found),
        .idx  (pick_idx)
    );

    mxs_addr #(.AW(AW)) u_addr (
        .clk (clk),
        .rst (rst),
        .load(addr_load),
        .step(addr_step),
        .base(start_base),
        .addr(mem_req_addr)
    );

    assign load_word     = mem_rsp_rdata;
    assign mem_req_write = store_mode;
    assign mem_req_wdata = rf_rd_data;
    assign rf_rd_idx     = cur_idx;
    assign rf_wr_idx     = cur_idx;
    assign rf_wr_data    = load_word;

    // R4: a store request carries the register being read.
    assert_store_data_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_write) |-> (mem_req_wdata == rf_rd_data && rf_rd_idx == rf_wr_idx));
    // R5: the request address is stable while waiting for the port.
    assert_req_addr_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> $stable(mem_req_addr));

endmodule

// File: tb/tb_fpr_mask_xfer_seq.sv
module tb_fpr_mask_xfer_seq;

    localparam int NR   = 8;
    localparam int AW   = 32;
    localparam int IW   = 3;
    localparam int VW   = 4;
    localparam int MW   = 16;
    localparam logic [AW-1:0] BASE = 32'h0000_1000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          start_store = 1'b0;
    logic [AW-1:0] start_base = '0;
    logic [NR-1:0] start_mask = '0;
    logic [VW-1:0] start_vl = '0;
    logic          busy, done;
    logic          mem_req_valid, mem_req_write;
    logic          mem_req_ready = 1'b0;
    logic [AW-1:0] mem_req_addr;
    logic [63:0]   mem_req_wdata;
    logic          mem_rsp_valid = 1'b0;
    logic [63:0]   mem_rsp_rdata = '0;
    logic [IW-1:0] rf_rd_idx, rf_wr_idx;
    logic [63:0]   rf_rd_data, rf_wr_data;
    logic          rf_wr_en;

    logic [63:0] rf [NR];
    logic [63:0] mem [MW];
    logic [63:0] rf_exp [NR];
    logic [63:0] mem_exp [MW];

    int  n_checks = 0;
    int  n_fail = 0;
    int  cyc = 0;
    int  nreq = 0;
    int  done_cnt = 0;
    int  done_cyc = 0;
    int  last_rsp_cyc = 0;
    logic [NR-1:0] cur_sel = '0;
    logic [AW-1:0] cur_base = '0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign rf_rd_data = rf[rf_rd_idx];

    fpr_mask_xfer_seq #(.NREG(NR), .AW(AW)) dut (
        .clk(clk), .rst(rst), .start(start), .start_store(start_store),
        .start_base(start_base), .start_mask(start_mask), .start_vl(start_vl),
        .busy(busy), .done(done),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_rdata(mem_rsp_rdata), .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
        .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Memory responder and register-file model, all activity away from the rising edge.
    initial begin
        logic [15:0]   lfsr = 16'hACE1;
        bit            hs_pend = 0, pend = 0, held = 0, p_write = 0;
        int            cnt = 0;
        logic [AW-1:0] p_addr = '0, h_addr = '0;
        logic [63:0]   p_wdata = '0;
        forever begin
            @(negedge clk);
            if (hs_pend) begin
                pend = 1;
                cnt = int'(lfsr[3]);
            end
            hs_pend = 0;
            mem_rsp_valid = 1'b0;
            if (pend) begin
                if (cnt == 0) begin
                    int w;
                    w = int'((p_addr - BASE) >> 3);
                    if (w >= 0 && w < MW) begin
                        if (p_write) mem[w] = p_wdata;
                        else mem_rsp_rdata = mem[w];
                    end
                    mem_rsp_valid = 1'b1;
                    pend = 0;
                    last_rsp_cyc = cyc;
                end else begin
                    cnt--;
                end
            end
            #1;
            if (rf_wr_en) begin
                chk(cur_sel[rf_wr_idx], "R3 write to unselected register", 64'(rf_wr_idx), 64'(cur_sel));
                rf[rf_wr_idx] = rf_wr_data;
            end
            if (done) begin
                done_cnt++;
                done_cyc = cyc;
            end
            if (mem_req_valid) begin
                if (pend || mem_rsp_valid)
                    chk(1'b0, "R6 request while one outstanding", 64'(mem_req_valid), 64'd0);
                if (held && mem_req_addr != h_addr)
                    chk(1'b0, "R5 request address changed while waiting", 64'(mem_req_addr), 64'(h_addr));
                mem_req_ready = lfsr[0] | lfsr[5];
                if (mem_req_ready) begin
                    chk(mem_req_addr == cur_base + AW'(8 * nreq), "R5 request address",
                        64'(mem_req_addr), 64'(cur_base + AW'(8 * nreq)));
                    hs_pend = 1;
                    p_addr = mem_req_addr;
                    p_write = mem_req_write;
                    p_wdata = mem_req_wdata;
                    nreq++;
                end
                held = !mem_req_ready;
                h_addr = mem_req_addr;
            end else begin
                mem_req_ready = 1'b0;
                held = 0;
            end
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        end
    end

    task automatic run_op(input int op, input bit st, input logic [NR-1:0] mask,
                          input int vl, input int bw, input bit poke);
        int lim, k, start_cyc, waited;
        bit ok;
        lim = (vl > NR) ? NR : vl;
        for (int i = 0; i < NR; i++) begin
            rf[i] = 64'hF000_0000_0000_0000 | (64'(op) << 8) | 64'(i);
            rf_exp[i] = rf[i];
        end
        for (int j = 0; j < MW; j++) begin
            mem[j] = 64'h0D00_0000_0000_0000 | (64'(op) << 8) | 64'(j);
            mem_exp[j] = mem[j];
        end
        k = 0;
        for (int i = 0; i < NR; i++) begin
            cur_sel[i] = mask[i] && (i < lim);
            if (cur_sel[i]) begin
                if (st) mem_exp[bw + k] = rf[i];
                else rf_exp[i] = mem[bw + k];
                k++;
            end
        end
        cur_base = BASE + AW'(8 * bw);
        nreq = 0;
        done_cnt = 0;
        start = 1'b1;
        start_store = st;
        start_base = cur_base;
        start_mask = mask;
        start_vl = VW'(vl);
        start_cyc = cyc;
        @(negedge clk);
        start = 1'b0;
        waited = 0;
        while (done_cnt == 0 && waited < 300) begin
            if (poke && waited == 3) begin
                start = 1'b1;
                start_store = ~st;
                start_mask = ~mask;
                start_base = BASE;
                start_vl = VW'(NR);
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            #2;
            waited++;
        end
        start = 1'b0;
        @(negedge clk);
        #2;
        @(negedge clk);
        #2;
        chk(done_cnt == 1, "R9 exactly one done pulse", 64'(done_cnt), 64'd1);
        if (k == 0)
            chk(done_cyc == start_cyc + 1, "R8 empty selection done timing", 64'(done_cyc), 64'(start_cyc + 1));
        else
            chk(done_cyc == last_rsp_cyc + 1, "R9 done after last response", 64'(done_cyc), 64'(last_rsp_cyc + 1));
        chk(nreq == k, poke ? "R10 request count with start while busy" : "R7 request count",
            64'(nreq), 64'(k));
        ok = 1;
        for (int i = 0; i < NR; i++) begin
            if (ok && rf[i] !== rf_exp[i]) begin
                chk(1'b0, st ? "R4 register file unchanged by store" : "R2 register contents after load",
                    rf[i], rf_exp[i]);
                ok = 0;
            end
        end
        if (ok) chk(1'b1, "R2", 64'd0, 64'd0);
        ok = 1;
        for (int j = 0; j < MW; j++) begin
            if (ok && mem[j] !== mem_exp[j]) begin
                chk(1'b0, st ? "R4 memory contents after store" : "R2 memory unchanged by load",
                    mem[j], mem_exp[j]);
                ok = 0;
            end
        end
        if (ok) chk(1'b1, "R4", 64'd0, 64'd0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        chk(1'b0, "watchdog expired", 64'(cyc), 64'd0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int op;
        int vls [4];
        vls[0] = 8; vls[1] = 5; vls[2] = 0; vls[3] = 12;
        for (int i = 0; i < NR; i++) rf[i] = '0;
        for (int j = 0; j < MW; j++) mem[j] = '0;
        repeat (3) @(negedge clk);
        #2;
        // R1: reset state
        chk(!busy && !done && !mem_req_valid && !rf_wr_en, "R1 outputs during reset",
            {60'd0, busy, done, mem_req_valid, rf_wr_en}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        #2;
        chk(!busy && !done && !mem_req_valid && !rf_wr_en, "R1 outputs after reset",
            {60'd0, busy, done, mem_req_valid, rf_wr_en}, 64'd0);
        @(negedge clk);
        op = 0;
        // R10: second start mid-command is ignored
        run_op(op++, 1'b0, 8'b1011_0111, 8, 2, 1'b1);
        run_op(op++, 1'b1, 8'b1101_1110, 8, 1, 1'b1);
        // Sweep: every mask, both directions, several lengths (R2 R3 R4 R7 R8)
        for (int d = 0; d < 2; d++) begin
            for (int v = 0; v < 4; v++) begin
                for (int m = 0; m < 256; m++) begin
                    run_op(op++, d[0], NR'(m), vls[v], m % 8, 1'b0);
                end
            end
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule